// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer Bank

This block holds five down-counting timer channels that share one write port and one control word. Each channel keeps a pair of buffer registers (reload count and compare threshold) that software may rewrite at any time. Those values reach the active counter and comparator only through a manual load, which is held for as long as its control bit stays set, or through an automatic reload when the counter wraps past zero. The first four channels drive a PWM pin. The fifth channel is a pure timer. Every channel emits a one-cycle pulse each time its count runs out.

Each channel is built around a three-state machine. `CH_IDLE` is stopped and holds its count. `CH_RUN` decrements on each tick. `CH_EXPIRED` rests at zero after a one-shot run. The transitions are: *arm* (`CH_IDLE`→`CH_RUN` when start is seen), *halt* (`CH_RUN` or `CH_EXPIRED`→`CH_IDLE` when start is cleared), *expire* (`CH_RUN`→`CH_EXPIRED` on a zero tick without auto-reload) and *rearm* (`CH_EXPIRED`→`CH_RUN` on a manual load while start is set). A per-channel tick enable, produced by an external prescaler, paces the counting.

Top module: `pwm_timer_bank`

## Requirements
- R1: Writes decode to three kinds of address. The control word is at 0x08. The reload count of channel n is at 0x0C+12n and its compare threshold is at 0x10+12n. A write to any other address (for example 0x04, 0x14 or 0x44) changes nothing.
- R2: Channel 0 owns control bits [3:0], and channel n≥1 owns the nibble starting at bit 4(n+1), so bits [7:4] control nothing. Inside a nibble, bit 0 is run, bit 1 is manual load, bit 2 is invert and bit 3 is auto-reload. Channel 4 is the exception: its auto-reload sits at nibble bit 2 and it has no invert.
- R3: While the manual-load bit is set, the channel copies both buffers into its active count and compare registers on every clock, and no counting takes place. A pin therefore shows the loaded values one clock after the bit is registered.
- R4: With run and auto-reload set and a tick on every clock, a reload count of N gives a zero pulse every N+1 clocks.
- R5: On the tick that leaves zero with auto-reload set, both buffers are copied into the active registers. A buffer write made in the middle of a cycle changes neither the current cycle nor the pin level.
- R6: With auto-reload clear, the counter runs to zero, emits one zero pulse and then rests at zero until a manual load restarts it.
- R7: The raw level is high while the count is at or below the compare value and low while it is above it. The invert bit flips the raw level. Only channels 0 to 3 have a pin, and over one period of a channel with N < 0xFFFF the pin is high for min(C,N)+1 clocks, or N−min(C,N) clocks when inverted.
- R8: An active compare value of all ones is never reached. The raw level stays low for the whole period, so an inverted pin is high 100% of the time.
- R9: While run is clear, ticks are ignored: the count, the compare value and the pin level hold, and no zero pulse appears.
- R10: After reset all buffers, active registers and control bits are zero, every pin is high, and no zero pulse is present.
- R11: A running channel whose tick enable is low does not count and emits no zero pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| tick | input | 5 | Per-channel count enable from the prescaler |
| pwm_out | output | 4 | PWM pins of channels 0 to 3 |
| zero_pulse | output | 5 | One-cycle pulse per channel when its count runs out |

## Verification
A register write is captured on one clock edge. A manual load then copies the buffers on the next edge, so a pin shows the new values two edges after the write edge. A zero pulse appears one clock after the tick that found the counter at zero. The bench drives and samples on falling edges. For the load-latency case it checks the pin on both falling edges that follow the write, so a load that lands one cycle early or one cycle late is caught. Periodic results (period length and high time) are measured only after at least two full periods of settling, and each high-time window spans exactly N+1 clocks. Because of this, the result does not depend on where the window starts.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_RUN     = 2'd1,
        CH_EXPIRED = 2'd2
    } ch_state_e;

    // byte offsets of the register window
    localparam int CTRL_OFS   = 8;
    localparam int BUF_BASE   = 12;
    localparam int BUF_STRIDE = 12;
    localparam int CMP_SKEW   = 4;

    // bit positions inside a channel nibble
    localparam int START_B    = 0;
    localparam int MUPD_B     = 1;
    localparam int INV_B      = 2;
    localparam int ARL_B      = 3;
    localparam int ARL_LAST_B = 2;

    // nibble slot of a channel: a one-slot hole follows channel 0
    function automatic int nib_index(input int ch);
        return (ch == 0) ? 0 : ch + 1;
    endfunction

endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
    import ptb_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf,
    output logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf,
    output logic [NUM_CH-1:0]            start,
    output logic [NUM_CH-1:0]            mupd,
    output logic [NUM_CH-1:0]            inv,
    output logic [NUM_CH-1:0]            arl
);

    localparam int LAST = NUM_CH - 1;

    function automatic logic [DATA_W-1:0] ctrl_used();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m[4*nib_index(c)+START_B] = 1'b1;
            m[4*nib_index(c)+MUPD_B]  = 1'b1;
            if (c == LAST) begin
                m[4*nib_index(c)+ARL_LAST_B] = 1'b1;
            end else begin
                m[4*nib_index(c)+INV_B] = 1'b1;
                m[4*nib_index(c)+ARL_B] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CTRL_USED = ctrl_used();

    logic              ctrl_hit;
    logic [NUM_CH-1:0] cnt_hit;
    logic [NUM_CH-1:0] cmp_hit;
    logic              any_hit;
    logic              wr_data_unused;

    assign wr_data_unused = ^(wr_data & ~CTRL_USED);
    assign ctrl_hit       = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cnt_hit[c] = wr_en && (wr_addr == ADDR_W'(BUF_BASE + BUF_STRIDE*c));
            cmp_hit[c] = wr_en && (wr_addr == ADDR_W'(BUF_BASE + BUF_STRIDE*c + CMP_SKEW));
        end
    end

    assign any_hit = ctrl_hit | (|cnt_hit) | (|cmp_hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start   <= '0;
            mupd    <= '0;
            inv     <= '0;
            arl     <= '0;
            cnt_buf <= '0;
            cmp_buf <= '0;
        end else begin
            if (ctrl_hit) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    start[c] <= wr_data[4*nib_index(c)+START_B];
                    mupd[c]  <= wr_data[4*nib_index(c)+MUPD_B];
                    if (c == LAST) begin
                        inv[c] <= 1'b0;
                        arl[c] <= wr_data[4*nib_index(c)+ARL_LAST_B];
                    end else begin
                        inv[c] <= wr_data[4*nib_index(c)+INV_B];
                        arl[c] <= wr_data[4*nib_index(c)+ARL_B];
                    end
                end
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (cnt_hit[c]) cnt_buf[c] <= wr_data[CNT_W-1:0];
                if (cmp_hit[c]) cmp_buf[c] <= wr_data[CNT_W-1:0];
            end
        end
    end

    // R1: an undecoded address leaves every register untouched
    p_stray_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_hit) |=> ($stable(cnt_buf) && $stable(cmp_buf) &&
                                 $stable(start) && $stable(mupd) && $stable(arl)))
        else $error("stray write changed a register");

    // R2: the timer-only channel never carries an invert bit
    p_last_no_invert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> !inv[LAST])
        else $error("timer-only channel took an invert bit");

endmodule

// File: rtl/ptb_channel.sv
module ptb_channel
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             mupd,
    input  logic             arl,
    input  logic             inv,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic             pwm,
    output logic             zero_pulse
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             at_zero;
    logic             step;
    logic             full_duty;

    assign at_zero = (cnt_q == '0);
    assign step    = (state_q == CH_RUN) && start && tick && !mupd;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:    if (start) state_d = CH_RUN;
            CH_RUN: begin
                if (!start)                       state_d = CH_IDLE;
                else if (step && at_zero && !arl) state_d = CH_EXPIRED;
            end
            CH_EXPIRED: begin
                if (!start)    state_d = CH_IDLE;
                else if (mupd) state_d = CH_RUN;
            end
            default:    state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // counter and active compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cmp_q      <= '0;
            zero_pulse <= 1'b0;
        end else begin
            zero_pulse <= step && at_zero;
            if (mupd) begin
                cnt_q <= cnt_buf;
                cmp_q <= cmp_buf;
            end else if (step) begin
                if (!at_zero) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (arl) begin
                    cnt_q <= cnt_buf;
                    cmp_q <= cmp_buf;
                end
            end
        end
    end

    // output level
    always_comb begin
        full_duty = &cmp_q;
        pwm       = ((cnt_q <= cmp_q) && !full_duty) ^ inv;
    end

    // R3: a held manual load copies the buffers
    p_manual_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mupd |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf)))
        else $error("manual load did not copy the buffers");

    // R4: a zero pulse follows only a tick taken at zero
    p_pulse_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> ($past(at_zero) && $past(tick) && $past(start)))
        else $error("zero pulse without a zero tick");

    // R6: a one-shot that has ended rests at zero
    p_expired_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_EXPIRED) |-> at_zero)
        else $error("expired channel left zero");

    // R8: all-ones compare keeps the raw level low
    p_full_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&cmp_q) |-> (pwm == inv))
        else $error("all-ones compare did not give full duty");

    // R9: a stopped channel holds its count and compare
    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !mupd) |=> ($stable(cnt_q) && $stable(cmp_q)))
        else $error("stopped channel moved");

    // R11: without a tick the count does not move
    p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !mupd) |=> $stable(cnt_q))
        else $error("count moved without a tick");

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import ptb_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] tick,
    output logic [NUM_CH-2:0] pwm_out,
    output logic [NUM_CH-1:0] zero_pulse
);

    localparam int NUM_PIN = NUM_CH - 1;

    logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
    logic [NUM_CH-1:0]            start;
    logic [NUM_CH-1:0]            mupd;
    logic [NUM_CH-1:0]            inv;
    logic [NUM_CH-1:0]            arl;
    logic                         last_pin_unused;

    ptb_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cnt_buf (cnt_buf),
        .cmp_buf (cmp_buf),
        .start   (start),
        .mupd    (mupd),
        .inv     (inv),
        .arl     (arl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (c < NUM_PIN) begin : g_pin
            ptb_channel #(.CNT_W(CNT_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick[c]),
                .start      (start[c]),
                .mupd       (mupd[c]),
                .arl        (arl[c]),
                .inv        (inv[c]),
                .cnt_buf    (cnt_buf[c]),
                .cmp_buf    (cmp_buf[c]),
                .pwm        (pwm_out[c]),
                .zero_pulse (zero_pulse[c])
            );
        end else begin : g_timer
            ptb_channel #(.CNT_W(CNT_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick[c]),
                .start      (start[c]),
                .mupd       (mupd[c]),
                .arl        (arl[c]),
                .inv        (inv[c]),
                .cnt_buf    (cnt_buf[c]),
                .cmp_buf    (cmp_buf[c]),
                .pwm        (last_pin_unused),
                .zero_pulse (zero_pulse[c])
            );
        end
    end

    // R10: nothing pulses in the first cycle out of reset
    p_quiet_after_reset_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> (zero_pulse == '0))
        else $error("zero pulse right after reset");

endmodule

// File: tb/tb_pwm_timer_bank.sv
module tb_pwm_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  tick = '1;
    logic [3:0]  pwm_out;
    logic [4:0]  zero_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pwm_timer_bank dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tick       (tick),
        .pwm_out    (pwm_out),
        .zero_pulse (zero_pulse)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nib(input int c);
        return (c == 0) ? 0 : c + 1;
    endfunction
    function automatic int b_start(input int c); return 1 << (4*nib(c)); endfunction
    function automatic int b_mupd(input int c);  return 1 << (4*nib(c) + 1); endfunction
    function automatic int b_inv(input int c);   return (c == 4) ? 0 : 1 << (4*nib(c) + 2); endfunction
    function automatic int b_arl(input int c);
        return (c == 4) ? 1 << (4*nib(c) + 2) : 1 << (4*nib(c) + 3);
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int c, input int n, input int cmp, input bit iv, input bit ar);
        int extra;
        extra = (iv ? b_inv(c) : 0);
        wr(12 + 12*c, n);
        wr(16 + 12*c, cmp);
        wr(8, b_mupd(c) | extra);
        wr(8, b_start(c) | extra | (ar ? b_arl(c) : 0));
    endtask

    task automatic period(input int c, output int p);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (zero_pulse[c]) break;
        end
        p = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            p++;
            if (zero_pulse[c]) break;
        end
    endtask

    task automatic high_time(input int c, input int n, output int h);
        h = 0;
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            h += int'(pwm_out[c]);
        end
    endtask

    task automatic pulses(input int c, input int len, output int np);
        np = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            np += int'(zero_pulse[c]);
        end
    endtask

    initial begin
        int p, h, np, exp_h;
        logic lvl;
        bit stable;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(pwm_out == 4'hF, "R10 pins after reset", int'(pwm_out), 15);
        check(zero_pulse == '0, "R10 no pulse after reset", int'(zero_pulse), 0);

        // R5: buffer writes alone do not reach the pin
        wr(12, 5);
        wr(16, 2);
        check(pwm_out[0] == 1'b1, "R5 buffer write idle pin", int'(pwm_out[0]), 1);
        // R3: manual load latency (write edge, then load edge)
        wr(8, b_mupd(0));
        check(pwm_out[0] == 1'b1, "R3 pin before load edge", int'(pwm_out[0]), 1);
        @(negedge clk);
        check(pwm_out[0] == 1'b0, "R3 pin after load edge", int'(pwm_out[0]), 0);
        wr(8, 0);

        // R4 R7 R2: sweep of channels, reload counts and thresholds
        for (int c = 0; c < 5; c++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int cmp = 0; cmp <= n + 1; cmp++) begin
                    bit iv;
                    iv = (cmp % 2) == 1;
                    setup(c, n, cmp, iv, 1'b1);
                    repeat (2*(n+1) + 4) @(negedge clk);
                    if (c < 4) begin
                        high_time(c, n, h);
                        exp_h = ((cmp < n) ? cmp : n) + 1;
                        if (iv) exp_h = n + 1 - exp_h;
                        check(h == exp_h, "R7 high time", h, exp_h);
                    end
                    period(c, p);
                    check(p == n + 1, "R4 period (R2 layout)", p, n + 1);
                end
            end
            wr(8, 0);
        end

        // R1: stray addresses change nothing
        setup(0, 3, 1, 1'b0, 1'b1);
        wr(4, 32'h00FF_FFFF);
        wr(20, 9);
        wr(68, 9);
        repeat (12) @(negedge clk);
        period(0, p);
        check(p == 4, "R1 period after stray writes", p, 4);
        high_time(0, 3, h);
        check(h == 2, "R1 high time after stray writes", h, 2);

        // R2: bits [7:4] are a hole
        wr(8, 32'h0000_00F0);
        pulses(1, 20, np);
        check(np == 0, "R2 hole bits start nothing", np, 0);

        // R5: mid-cycle buffer write waits for the reload
        setup(1, 7, 3, 1'b0, 1'b1);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (zero_pulse[1]) break;
        end
        p = 0;
        for (int k = 0; k < 300; k++) begin
            if (k == 0) begin wr_en = 1'b1; wr_addr = 8'd24; wr_data = 32'd2; end
            @(negedge clk);
            wr_en = 1'b0;
            p++;
            if (zero_pulse[1]) break;
        end
        check(p == 8, "R5 current cycle kept", p, 8);
        period(1, p);
        check(p == 3, "R5 new count after reload", p, 3);
        wr(8, 0);

        // R6: one-shot then rearm
        setup(2, 3, 1, 1'b0, 1'b0);
        pulses(2, 30, np);
        check(np == 1, "R6 one-shot single pulse", np, 1);
        check(pwm_out[2] == 1'b1, "R6 resting pin level", int'(pwm_out[2]), 1);
        wr(8, b_start(2) | b_mupd(2));
        wr(8, b_start(2));
        pulses(2, 30, np);
        check(np == 1, "R6 rearm single pulse", np, 1);

        // R9: stopped channel holds
        setup(3, 5, 2, 1'b0, 1'b1);
        repeat (9) @(negedge clk);
        wr(8, b_arl(3));
        lvl = pwm_out[3];
        stable = 1'b1;
        np = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out[3] != lvl) stable = 1'b0;
            np += int'(zero_pulse[3]);
        end
        check(stable, "R9 pin holds while stopped", int'(pwm_out[3]), int'(lvl));
        check(np == 0, "R9 no pulse while stopped", np, 0);
        wr(8, b_start(3) | b_arl(3));
        period(3, p);
        check(p == 6, "R9 period after restart", p, 6);

        // R11: tick enable gates counting
        setup(0, 4, 2, 1'b0, 1'b1);
        repeat (6) @(negedge clk);
        tick[0] = 1'b0;
        @(negedge clk);
        lvl = pwm_out[0];
        stable = 1'b1;
        np = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (pwm_out[0] != lvl) stable = 1'b0;
            np += int'(zero_pulse[0]);
        end
        check(np == 0, "R11 no pulse without tick", np, 0);
        check(stable, "R11 pin holds without tick", int'(pwm_out[0]), int'(lvl));
        tick[0] = 1'b1;
        period(0, p);
        check(p == 5, "R11 period after tick returns", p, 5);

        // R8: all-ones threshold
        setup(0, 3, 32'h0000_FFFF, 1'b1, 1'b1);
        repeat (10) @(negedge clk);
        high_time(0, 3, h);
        check(h == 4, "R8 inverted full duty", h, 4);
        setup(0, 3, 32'h0000_FFFF, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        high_time(0, 3, h);
        check(h == 0, "R8 raw never high", h, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule